// File: doc/BRIEF.md
# Multi-Task Call and Branch Unit

This block decodes the branch-class instructions of a small 32-bit processor that interleaves several hardware tasks. For the instruction issued in a cycle, it works out the next program counter of the issuing task and says whether a branch is taken. It also saves and restores return addresses for that task. The unit is purely combinational from instruction to outputs. Its state is updated on the clock edge that ends the issue cycle.

There are two places to keep return addresses. Each task owns a shallow hardware LIFO, which stack calls push and returns pop. Each task also owns a private link register, which link calls write without touching the LIFO. The pipeline reads the issuing task's link register through `link_o` and can pass it back as the register operand of an indirect jump. Register-indirect branches can also reload the Z and C flags from the top two bits of the operand, so a routine can return and restore the caller's flags in one instruction.

Instruction encoding: bits 31:25 equal to 1111110 mark a unit instruction. Bits 24:22 give the class, bits 21:18 the condition `cc`, bits 17:16 the mode or sub-operation, and bits 15:0 the address field `n`.

Top module: `cbu_unit`

## Requirements
- R1: An instruction executes only when bit `cc[{C,Z}]` of its condition field is 1. Otherwise there is no push, no pop, no link write and no flag load, `taken_o` is 0 and `next_pc_o` is `pc_i+1`.
- R2: The immediate forms (class 011 stack call, 010 link call, 001 jump) branch to `n` when mode bit 16 is 0. They branch to `pc_i+n` modulo 2^16 when mode bit 16 is 1.
- R3: The return address of an immediate call is `pc_i+4` when mode bit 17 is 1 (delayed) and `pc_i+1` when it is 0. Register-form calls always use `pc_i+1`.
- R4: A stack call (class 011, or class 000 with sub 01) pushes its return address onto the issuing task's LIFO in the same cycle. A return (class 000, sub 11) pops it and branches to the popped value.
- R5: A link call (class 010, or class 000 with sub 10) writes its return address into the issuing task's link register. `link_o` shows the new value from the next cycle, and the LIFO is left unchanged.
- R6: A push, pop or link write by one task never changes the LIFO contents, link register or error flag of another task.
- R7: Register forms (class 000, sub 00 jump, 01 stack call, 10 link call) branch to `dreg_i[15:0]`. Bit 15 of the word requests a Z load from `dreg_i[31]` and bit 14 requests a C load from `dreg_i[30]`. A return never loads flags.
- R8: A push onto a task's full 4-entry LIFO discards the oldest entry, keeps the newest four and sets that task's sticky error bit.
- R9: A return or pop on an empty LIFO yields 0 and sets the task's sticky error bit.
- R10: A pop instruction (class 100) puts the top entry on `pop_data_o` and removes it, and does not branch.
- R11: After reset every LIFO is empty, every link register reads 0 and every error bit is 0.
- R12: A word whose bits 31:25 are not 1111110, a word with class 101, 110 or 111, or a cycle with `issue_i` low has no effect on outputs or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| task_i | input | 2 | Issuing task |
| pc_i | input | 16 | Program counter of the issuing task |
| dreg_i | input | 32 | Register operand for indirect forms |
| flag_z_i | input | 1 | Current Z flag |
| flag_c_i | input | 1 | Current C flag |
| next_pc_o | output | 16 | Next program counter of the task |
| taken_o | output | 1 | Branch taken |
| push_o | output | 1 | LIFO push this cycle |
| pop_o | output | 1 | LIFO pop this cycle |
| pop_data_o | output | 16 | Popped entry (0 when not popping) |
| link_wr_o | output | 1 | Link register written this cycle |
| link_data_o | output | 16 | Return address being saved |
| link_o | output | 16 | Link register of `task_i` |
| z_load_o | output | 1 | Load Z |
| z_val_o | output | 1 | New Z value |
| c_load_o | output | 1 | Load C |
| c_val_o | output | 1 | New C value |
| stk_err_o | output | 4 | Sticky LIFO error per task |

## Verification
Directed sequences use each immediate mode with absolute and relative targets, delayed and plain. These show the target arithmetic and the return-address offset as separate effects. Deep call chains on one task, with a second task issuing in between, overflow and then drain its LIFO. This separates the drop-oldest rule and the empty-pop rule from leakage across tasks. Link calls on one task are followed by reads on the others to expose any shared link storage. A long random stream mixes tasks, classes, false conditions and foreign opcodes. It is compared every cycle against a queue-based model, so ordering faults and gating faults show up as mismatches.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam logic [6:0] CBU_MAJOR = 7'b1111110;

  typedef enum logic [2:0] {
    CLS_REG   = 3'b000,
    CLS_JMP   = 3'b001,
    CLS_LCALL = 3'b010,
    CLS_SCALL = 3'b011,
    CLS_POP   = 3'b100
  } cbu_cls_e;

  typedef enum logic [1:0] {
    SUB_JMPD  = 2'b00,
    SUB_SCALLD = 2'b01,
    SUB_LCALLD = 2'b10,
    SUB_RET   = 2'b11
  } cbu_sub_e;

  // condition passes when the bit selected by the flag pair is set
  function automatic logic cond_pass(input logic [3:0] cc, input logic z, input logic c);
    return cc[{c, z}];
  endfunction

endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          issue_i,
  input  logic [31:0]   instr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [31:0]   dreg_i,
  input  logic          z_i,
  input  logic          c_i,
  output logic          exec_o,
  output logic          jump_o,
  output logic          use_stack_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          link_o,
  output logic          ld_z_o,
  output logic          ld_c_o,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] ret_o
);

  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] FOUR = AW'(4);

  function automatic logic [AW-1:0] imm_target(input logic [AW-1:0] pc, input logic rel,
                                               input logic [15:0] n);
    return rel ? pc + AW'(n) : AW'(n);
  endfunction

  function automatic logic [AW-1:0] ret_addr(input logic [AW-1:0] pc, input logic delayed);
    return delayed ? pc + FOUR : pc + ONE;
  endfunction

  logic       ours;
  logic       known;
  logic [2:0] cls;
  logic [1:0] mm;
  logic [15:0] nfield;

  assign cls    = instr_i[24:22];
  assign mm     = instr_i[17:16];
  assign nfield = instr_i[15:0];
  assign ours   = issue_i && (instr_i[31:25] == CBU_MAJOR);
  assign known  = (cls <= 3'b100);
  assign exec_o = ours && known && cond_pass(instr_i[21:18], z_i, c_i);

  always_comb begin
    jump_o      = 1'b0;
    use_stack_o = 1'b0;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    link_o      = 1'b0;
    ld_z_o      = 1'b0;
    ld_c_o      = 1'b0;
    target_o    = imm_target(pc_i, mm[0], nfield);
    ret_o       = ret_addr(pc_i, mm[1]);
    if (exec_o) begin
      unique case (cls)
        CLS_SCALL: begin jump_o = 1'b1; push_o = 1'b1; end
        CLS_LCALL: begin jump_o = 1'b1; link_o = 1'b1; end
        CLS_JMP:   jump_o = 1'b1;
        CLS_POP:   pop_o = 1'b1;
        CLS_REG: begin
          target_o = dreg_i[AW-1:0];
          ret_o    = pc_i + ONE;
          jump_o   = 1'b1;
          if (mm == SUB_RET) begin
            pop_o       = 1'b1;
            use_stack_o = 1'b1;
          end else begin
            ld_z_o = instr_i[15];
            ld_c_o = instr_i[14];
            push_o = (mm == SUB_SCALLD);
            link_o = (mm == SUB_LCALLD);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cbu_rstack.sv
module cbu_rstack #(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] top_o,
  output logic          err_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] ent [DEPTH];
  logic [CW-1:0] level;
  logic          is_full;
  logic          is_empty;

  assign is_full  = (level == FULL);
  assign is_empty = (level == '0);
  assign top_o    = is_empty ? '0 : ent[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      level <= '0;
      err_o <= 1'b0;
    end else if (push_i) begin
      for (int i = DEPTH - 1; i > 0; i--) ent[i] <= ent[i-1];
      ent[0] <= data_i;
      if (is_full) err_o <= 1'b1;
      else         level <= level + CW'(1);
    end else if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
      ent[DEPTH-1] <= '0;
      if (is_empty) err_o <= 1'b1;
      else          level <= level - CW'(1);
    end
  end

endmodule

// File: rtl/cbu_link.sv
module cbu_link #(
  parameter int NTASK = 4,
  parameter int AW    = 16,
  localparam int TW   = $clog2(NTASK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [TW-1:0]     sel_i,
  input  logic [AW-1:0]     data_i,
  output logic [AW-1:0]     rd_o,
  output logic [NTASK*AW-1:0] all_o
);

  logic [AW-1:0] lr [NTASK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTASK; t++) lr[t] <= '0;
    end else if (wr_i) begin
      lr[sel_i] <= data_i;
    end
  end

  assign rd_o = lr[sel_i];

  for (genvar t = 0; t < NTASK; t++) begin : g_flat
    assign all_o[t*AW +: AW] = lr[t];
  end

endmodule

// File: rtl/cbu_unit.sv
module cbu_unit #(
  parameter int NTASK = 4,
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int TW   = $clog2(NTASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [31:0]      instr_i,
  input  logic [TW-1:0]    task_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [31:0]      dreg_i,
  input  logic             flag_z_i,
  input  logic             flag_c_i,
  output logic [AW-1:0]    next_pc_o,
  output logic             taken_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [AW-1:0]    pop_data_o,
  output logic             link_wr_o,
  output logic [AW-1:0]    link_data_o,
  output logic [AW-1:0]    link_o,
  output logic             z_load_o,
  output logic             z_val_o,
  output logic             c_load_o,
  output logic             c_val_o,
  output logic [NTASK-1:0] stk_err_o
);

  logic          dec_exec;
  logic          dec_jump;
  logic          dec_use_stack;
  logic          dec_push;
  logic          dec_pop;
  logic          dec_link;
  logic          dec_ld_z;
  logic          dec_ld_c;
  logic [AW-1:0] dec_target;
  logic [AW-1:0] dec_ret;
  logic [AW-1:0] tops [NTASK];
  logic [AW-1:0] cur_top;
  logic [NTASK*AW-1:0] link_flat;

  cbu_decode #(.AW(AW)) u_dec (
    .issue_i     (issue_i),
    .instr_i     (instr_i),
    .pc_i        (pc_i),
    .dreg_i      (dreg_i),
    .z_i         (flag_z_i),
    .c_i         (flag_c_i),
    .exec_o      (dec_exec),
    .jump_o      (dec_jump),
    .use_stack_o (dec_use_stack),
    .push_o      (dec_push),
    .pop_o       (dec_pop),
    .link_o      (dec_link),
    .ld_z_o      (dec_ld_z),
    .ld_c_o      (dec_ld_c),
    .target_o    (dec_target),
    .ret_o       (dec_ret)
  );

  for (genvar t = 0; t < NTASK; t++) begin : g_task
    logic mine;
    assign mine = (task_i == TW'(t));
    cbu_rstack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (dec_push && mine),
      .pop_i  (dec_pop && mine),
      .data_i (dec_ret),
      .top_o  (tops[t]),
      .err_o  (stk_err_o[t])
    );
  end

  cbu_link #(.NTASK(NTASK), .AW(AW)) u_link (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (dec_link),
    .sel_i  (task_i),
    .data_i (dec_ret),
    .rd_o   (link_o),
    .all_o  (link_flat)
  );

  assign cur_top     = tops[task_i];
  assign taken_o     = dec_jump;
  assign next_pc_o   = dec_jump ? (dec_use_stack ? cur_top : dec_target) : pc_i + AW'(1);
  assign push_o      = dec_push;
  assign pop_o       = dec_pop;
  assign pop_data_o  = dec_pop ? cur_top : '0;
  assign link_wr_o   = dec_link;
  assign link_data_o = dec_ret;
  assign z_load_o    = dec_ld_z;
  assign c_load_o    = dec_ld_c;
  assign z_val_o     = dreg_i[31];
  assign c_val_o     = dreg_i[30];

endmodule

// File: rtl/cbu_unit_chk.sv
module cbu_unit_chk #(
  parameter int NTASK = 4,
  parameter int AW    = 16,
  localparam int TW   = $clog2(NTASK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic [TW-1:0]    task_i,
  input logic [AW-1:0]    pc_i,
  input logic             dec_exec,
  input logic [AW-1:0]    next_pc_o,
  input logic             taken_o,
  input logic             push_o,
  input logic             pop_o,
  input logic             link_wr_o,
  input logic [AW-1:0]    link_data_o,
  input logic             z_load_o,
  input logic             c_load_o,
  input logic [NTASK*AW-1:0] link_flat,
  input logic [NTASK-1:0] stk_err_o
);

  // R1: a gated-off instruction leaves every effect idle
  a_r1_cond_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_exec |-> (!taken_o && !push_o && !pop_o && !link_wr_o && !z_load_o && !c_load_o
                   && next_pc_o == pc_i + AW'(1)));

  // R4: push and pop never in the same cycle
  a_r4_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && pop_o));

  // R7: flag loads only ride on a taken branch
  a_r7_flag_with_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (z_load_o || c_load_o) |-> taken_o);

  for (genvar t = 0; t < NTASK; t++) begin : g_t
    // R8: error bits are sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stk_err_o[t] |=> stk_err_o[t]);
    // R5: a link write lands in the issuing task's register
    a_r5_link_write: assert property (@(posedge clk) disable iff (!rst_n)
      (link_wr_o && task_i == TW'(t)) |=> link_flat[t*AW +: AW] == $past(link_data_o));
    // R6: other tasks' link registers hold
    a_r6_link_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_wr_o && task_i == TW'(t)) |=> $stable(link_flat[t*AW +: AW]));
  end

endmodule

bind cbu_unit cbu_unit_chk #(.NTASK(NTASK), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_i     (issue_i),
  .task_i      (task_i),
  .pc_i        (pc_i),
  .dec_exec    (dec_exec),
  .next_pc_o   (next_pc_o),
  .taken_o     (taken_o),
  .push_o      (push_o),
  .pop_o       (pop_o),
  .link_wr_o   (link_wr_o),
  .link_data_o (link_data_o),
  .z_load_o    (z_load_o),
  .c_load_o    (c_load_o),
  .link_flat   (link_flat),
  .stk_err_o   (stk_err_o)
);

// File: tb/cbu_unit_test.sv
`timescale 1ns/1ps
module cbu_unit_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        issue_i = 0;
  logic [31:0] instr_i = 0;
  logic [1:0]  task_i = 0;
  logic [15:0] pc_i = 0;
  logic [31:0] dreg_i = 0;
  logic        flag_z_i = 0, flag_c_i = 0;
  logic [15:0] next_pc_o, pop_data_o, link_data_o, link_o;
  logic        taken_o, push_o, pop_o, link_wr_o, z_load_o, z_val_o, c_load_o, c_val_o;
  logic [3:0]  stk_err_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cbu_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i), .task_i(task_i),
    .pc_i(pc_i), .dreg_i(dreg_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i),
    .next_pc_o(next_pc_o), .taken_o(taken_o), .push_o(push_o), .pop_o(pop_o),
    .pop_data_o(pop_data_o), .link_wr_o(link_wr_o), .link_data_o(link_data_o),
    .link_o(link_o), .z_load_o(z_load_o), .z_val_o(z_val_o), .c_load_o(c_load_o),
    .c_val_o(c_val_o), .stk_err_o(stk_err_o)
  );

  // reference state
  int unsigned m_stk [4][$];
  int unsigned m_lr  [4];
  bit          m_err [4];

  function automatic logic [31:0] mk(input int cls, input int cc, input int mm, input int n);
    return {7'b1111110, 3'(cls), 4'(cc), 2'(mm), 16'(n)};
  endfunction

  task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input int tsk, input int unsigned pc,
                      input logic [31:0] d, input bit z, input bit c, input bit iss,
                      input string tag);
    bit run, e_taken, e_push, e_pop, e_lw, e_lz, e_lc;
    int unsigned e_next, e_ret, e_pdata, tgt, n;
    int cls, mm;
    @(negedge clk);
    issue_i = iss; instr_i = ins; task_i = 2'(tsk); pc_i = 16'(pc); dreg_i = d;
    flag_z_i = z; flag_c_i = c;
    #2;
    cls = int'(ins[24:22]); mm = int'(ins[17:16]); n = ins[15:0];
    run = iss && ins[31:25] == 7'h7E && cls <= 4 && ins[18 + (c ? 2 : 0) + (z ? 1 : 0)];
    e_taken = 0; e_push = 0; e_pop = 0; e_lw = 0; e_lz = 0; e_lc = 0; e_pdata = 0;
    e_next = (pc + 1) % 65536;
    tgt = mm[0] ? (pc + n) % 65536 : n;
    e_ret = mm[1] ? (pc + 4) % 65536 : (pc + 1) % 65536;
    if (run) begin
      if (cls == 3) begin e_taken = 1; e_push = 1; e_next = tgt; end
      else if (cls == 2) begin e_taken = 1; e_lw = 1; e_next = tgt; end
      else if (cls == 1) begin e_taken = 1; e_next = tgt; end
      else if (cls == 4) begin
        e_pop = 1; e_pdata = (m_stk[tsk].size() > 0) ? m_stk[tsk][0] : 0;
      end else begin
        e_taken = 1; e_ret = (pc + 1) % 65536;
        if (mm == 3) begin
          e_pop = 1; e_pdata = (m_stk[tsk].size() > 0) ? m_stk[tsk][0] : 0;
          e_next = e_pdata;
        end else begin
          e_next = d[15:0]; e_lz = ins[15]; e_lc = ins[14];
          e_push = (mm == 1); e_lw = (mm == 2);
        end
      end
    end
    chk(tag, "next_pc", next_pc_o, e_next);
    chk(tag, "taken", taken_o, e_taken);
    chk(tag, "push", push_o, e_push);
    chk(tag, "pop", pop_o, e_pop);
    chk(tag, "pop_data", pop_data_o, e_pdata);
    chk(tag, "link_wr", link_wr_o, e_lw);
    if (e_lw || e_push) chk(tag, "ret_addr", link_data_o, e_ret);
    chk(tag, "z_load", z_load_o, e_lz);
    chk(tag, "c_load", c_load_o, e_lc);
    if (e_lz) chk(tag, "z_val", z_val_o, d[31]);
    if (e_lc) chk(tag, "c_val", c_val_o, d[30]);
    chk(tag, "link", link_o, m_lr[tsk]);
    chk(tag, "err", stk_err_o, {m_err[3], m_err[2], m_err[1], m_err[0]});
    @(posedge clk);
    if (e_push) begin
      m_stk[tsk].push_front(e_ret);
      if (m_stk[tsk].size() > 4) begin void'(m_stk[tsk].pop_back()); m_err[tsk] = 1; end
    end
    if (e_pop) begin
      if (m_stk[tsk].size() == 0) m_err[tsk] = 1;
      else void'(m_stk[tsk].pop_front());
    end
    if (e_lw) m_lr[tsk] = e_ret;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++) begin m_lr[t] = 0; m_err[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R11 reset state seen per task
    for (int t = 0; t < 4; t++) step(32'h0, t, 16'h10, 0, 0, 0, 0, "R11");
    // R2 R3 immediate modes on task 0
    step(mk(3, 15, 0, 16'h2000), 0, 16'h0100, 0, 0, 0, 1, "R2");
    step(mk(3, 15, 1, 16'h0010), 0, 16'h0200, 0, 0, 0, 1, "R2");
    step(mk(3, 15, 2, 16'h3000), 0, 16'h0300, 0, 0, 0, 1, "R3");
    step(mk(3, 15, 3, 16'hFFFF), 0, 16'h0400, 0, 0, 0, 1, "R3");
    step(mk(1, 15, 1, 16'h0005), 0, 16'hFFFE, 0, 0, 0, 1, "R2");
    // R6 another task issues between
    step(mk(3, 15, 0, 16'h0700), 1, 16'h0050, 0, 0, 0, 1, "R6");
    // R4 returns on task 0 unwind in LIFO order
    for (int i = 0; i < 4; i++) step(mk(0, 15, 3, 0), 0, 16'h0999, 0, 0, 0, 1, "R4");
    // R9 empty return then empty pop
    step(mk(0, 15, 3, 0), 0, 16'h0999, 0, 0, 0, 1, "R9");
    step(mk(4, 15, 0, 0), 2, 16'h0001, 0, 0, 0, 1, "R9");
    // R10 pop instruction on task 1
    step(mk(4, 15, 0, 0), 1, 16'h0060, 0, 0, 0, 1, "R10");
    // R5 link calls, read back on each task
    step(mk(2, 15, 0, 16'h1234), 1, 16'h0080, 0, 0, 0, 1, "R5");
    step(mk(2, 15, 2, 16'h1234), 3, 16'h0090, 0, 0, 0, 1, "R5");
    for (int t = 0; t < 4; t++) step(32'h0, t, 0, 0, 0, 0, 0, "R6");
    // R7 register forms with flag restore
    step(mk(0, 15, 0, 16'hC000), 1, 16'h0100, 32'h8000_4321, 0, 0, 1, "R7");
    step(mk(0, 15, 1, 16'h4000), 2, 16'h0110, 32'h4000_0777, 0, 0, 1, "R7");
    step(mk(0, 15, 2, 16'h8000), 3, 16'h0120, 32'hC000_0888, 0, 0, 1, "R7");
    step(mk(0, 15, 3, 16'hC000), 2, 16'h0130, 32'hC000_0000, 0, 0, 1, "R7");
    // R8 overflow on task 3
    for (int i = 0; i < 6; i++) step(mk(3, 15, 0, 16'h0400), 3, 16'h0010 * i, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 5; i++) step(mk(0, 15, 3, 0), 3, 0, 0, 0, 0, 1, "R8");
    // R1 condition gating
    step(mk(3, 0, 0, 16'h0400), 0, 16'h0040, 0, 1, 1, 1, "R1");
    step(mk(2, 4'b0010, 0, 16'h0400), 0, 16'h0041, 0, 0, 0, 1, "R1");
    step(mk(2, 4'b0010, 0, 16'h0400), 0, 16'h0042, 0, 1, 0, 1, "R1");
    step(mk(0, 4'b1000, 3, 0), 0, 16'h0043, 0, 0, 1, 1, "R1");
    // R12 foreign opcode, bad class, no issue
    step({7'h3E, 25'h0FF_FFFF}, 0, 16'h0050, 0, 0, 0, 1, "R12");
    step(mk(6, 15, 0, 16'h0400), 0, 16'h0051, 0, 0, 0, 1, "R12");
    step(mk(3, 15, 0, 16'h0400), 0, 16'h0052, 0, 0, 0, 0, "R12");
    step(mk(4, 15, 0, 0), 0, 16'h0053, 0, 0, 0, 1, "R12");
    // mixed random stream
    for (int i = 0; i < 3000; i++) begin
      int cls, cc;
      logic [31:0] ins;
      cls = int'($urandom_range(0, 5));
      cc = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : 15;
      ins = mk(cls, cc, int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)));
      if ($urandom_range(0, 19) == 0) ins[31:25] = 7'(($urandom_range(0, 127)));
      step(ins, int'($urandom_range(0, 3)), $urandom_range(0, 65535), $urandom,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) != 0),
           cls == 3 ? "R4" : cls == 2 ? "R5" : cls == 0 ? "R7" : cls == 4 ? "R10" : "R2");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule